// File: doc/BRIEF.md
# Interrupting GPIO Bank

A bank of up to 32 bidirectional general-purpose pins controlled through four word-wide registers on a simple synchronous bus. Software picks, per pin, whether the bank drives the pin or listens to it. It writes output values and reads back the synchronised level present on every pin. A per-pin enable selects which pins may raise the single interrupt line.

The trigger kind is fixed when the bank is built. In rising, falling or either-edge mode, each qualifying transition of a synchronised input latches a sticky capture bit. Software clears a capture bit by writing a one to it. The interrupt is raised while any captured bit is enabled. In level mode the capture register stays empty, and the interrupt follows the enabled pins that are currently high.

The bus side is a two-state machine. In BUS_IDLE, a request takes the "accept" transition: any write lands on that edge, the read word is latched, and the machine enters BUS_RESP. BUS_RESP asserts ready for exactly one cycle, ignores the request line, and takes the "complete" transition back to BUS_IDLE.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset the direction, enable and capture registers read zero, every output enable is low, the interrupt is low and ready is low.
- R2: Bits [3:2] of the byte address select the register: 0x0 pin data, 0x4 direction, 0x8 interrupt enable, 0xC edge capture. A request seen in BUS_IDLE produces ready high in the following cycle, for one cycle only.
- R3: Output enable bit i equals direction bit i (1 = drive, 0 = listen), and output value bit i equals the last value written to data bit i.
- R4: A data read returns each pin's level after a two-flop synchroniser. Bits at and above the pin count read zero in every register, and writes to them are dropped.
- R5: Trigger encoding 0 captures rising edges, 1 falling edges and 2 both. Each qualifying edge of a synchronised input sets that pin's capture bit.
- R6: Writing a one to a capture bit clears it. Writing a zero leaves it unchanged.
- R7: When an edge and a clearing write hit the same capture bit in the same cycle, the bit stays set.
- R8: In the edge modes the registered interrupt is high one cycle after any capture bit is set together with its enable bit, and low once none is.
- R9: In level mode (encoding 3) the capture register stays zero, and the interrupt is high exactly when some enabled pin is high after synchronisation.
- R10: A pin whose enable bit is zero never raises the interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address, bits [3:2] select the register |
| bus_wdata | input | 32 | Write word |
| bus_rdata | output | 32 | Read word, valid while bus_ready is high |
| bus_ready | output | 1 | One-cycle completion strobe |
| pin_in | input | NUM_PINS | Pad levels seen by the bank |
| pin_out | output | NUM_PINS | Values to drive |
| pin_oe | output | NUM_PINS | Drive enables |
| irq | output | 1 | Registered interrupt |

## Verification
The hardest case to reach is an edge landing on a capture bit in the very cycle a clearing write arrives. Only an exact count of the synchroniser and edge-detector registers puts both on the same clock edge. The bench first arms pin 0 with a rising edge. It then drops the pin and issues the clearing write so that its request is sampled on the third rising clock edge after the change, which is the edge that records the falling transition. The rising-only instance must then lose the bit, while the either-edge and falling instances must keep it.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    localparam int BUS_W    = 32;
    localparam int MAX_PINS = 32;
    localparam int SEL_LSB  = 2;

    typedef enum logic [1:0] {
        TRIG_RISE  = 2'd0,
        TRIG_FALL  = 2'd1,
        TRIG_BOTH  = 2'd2,
        TRIG_LEVEL = 2'd3
    } trig_e;

    typedef enum logic [1:0] {
        REG_DATA = 2'd0,
        REG_DIR  = 2'd1,
        REG_MASK = 2'd2,
        REG_CAP  = 2'd3
    } reg_sel_e;

    typedef enum logic {
        BUS_IDLE = 1'b0,
        BUS_RESP = 1'b1
    } bus_st_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= d;
            end
        end else begin : g_rest
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_edge_cap.sv
module gpio_edge_cap
    import gpio_pkg::*;
#(
    parameter int    W    = 8,
    parameter trig_e TRIG = TRIG_RISE
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl,
    input  logic         clr_en,
    input  logic [W-1:0] clr_mask,
    output logic [W-1:0] cap
);
    logic [W-1:0] prev_q;
    logic [W-1:0] hit;
    logic [W-1:0] cap_q;
    logic [W-1:0] clr_bits;

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= lvl;
    end

    if (TRIG == TRIG_RISE) begin : g_rise
        assign hit = lvl & ~prev_q;
    end else if (TRIG == TRIG_FALL) begin : g_fall
        assign hit = ~lvl & prev_q;
    end else if (TRIG == TRIG_BOTH) begin : g_both
        assign hit = lvl ^ prev_q;
    end else begin : g_level
        assign hit = '0;
    end

    assign clr_bits = clr_en ? clr_mask : '0;

    // a fresh edge wins over a clear aimed at the same bit
    always_ff @(posedge clk) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= (cap_q & ~clr_bits) | hit;
    end

    assign cap = cap_q;
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_pkg::*;
#(
    parameter int W      = 8,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              bus_ready,
    input  logic [W-1:0]      lvl,
    input  logic [W-1:0]      cap,
    output logic [W-1:0]      data_q,
    output logic [W-1:0]      dir_q,
    output logic [W-1:0]      mask_q,
    output logic              cap_clr_en,
    output logic [W-1:0]      cap_clr_mask
);
    bus_st_e          state_q, state_nx;
    reg_sel_e         sel;
    logic             accept;
    logic [BUS_W-1:0] rd_word;
    logic [BUS_W-1:0] rdata_q;

    assign sel = reg_sel_e'(bus_addr[SEL_LSB+1:SEL_LSB]);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= BUS_IDLE;
        else        state_q <= state_nx;
    end

    // transitions: accept (IDLE->RESP), complete (RESP->IDLE)
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            BUS_IDLE: if (bus_req) state_nx = BUS_RESP;
            BUS_RESP: state_nx = BUS_IDLE;
        endcase
    end

    // outputs of the state machine
    always_comb begin
        accept    = 1'b0;
        bus_ready = 1'b0;
        unique case (state_q)
            BUS_IDLE: accept    = bus_req;
            BUS_RESP: bus_ready = 1'b1;
        endcase
    end

    assign cap_clr_en   = accept && bus_we && (sel == REG_CAP);
    assign cap_clr_mask = bus_wdata[W-1:0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            dir_q  <= '0;
            mask_q <= '0;
        end else if (accept && bus_we) begin
            unique case (sel)
                REG_DATA: data_q <= bus_wdata[W-1:0];
                REG_DIR:  dir_q  <= bus_wdata[W-1:0];
                REG_MASK: mask_q <= bus_wdata[W-1:0];
                REG_CAP:  ;
            endcase
        end
    end

    always_comb begin
        rd_word = '0;
        unique case (sel)
            REG_DATA: rd_word[W-1:0] = lvl;
            REG_DIR:  rd_word[W-1:0] = dir_q;
            REG_MASK: rd_word[W-1:0] = mask_q;
            REG_CAP:  rd_word[W-1:0] = cap;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      rdata_q <= '0;
        else if (accept) rdata_q <= rd_word;
    end

    assign bus_rdata = rdata_q;
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
    import gpio_pkg::*;
#(
    parameter int    NUM_PINS = 8,
    parameter trig_e TRIG     = TRIG_RISE,
    parameter int    ADDR_W   = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_req,
    input  logic                bus_we,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    output logic                bus_ready,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] pin_out,
    output logic [NUM_PINS-1:0] pin_oe,
    output logic                irq
);
    localparam int SYNC_STAGES = 2;

    logic [NUM_PINS-1:0] lvl_q;
    logic [NUM_PINS-1:0] cap_q;
    logic [NUM_PINS-1:0] data_q;
    logic [NUM_PINS-1:0] dir_q;
    logic [NUM_PINS-1:0] mask_q;
    logic [NUM_PINS-1:0] cap_clr_mask;
    logic                cap_clr_en;
    logic [NUM_PINS-1:0] irq_src;
    logic                irq_q;

    initial begin
        if (NUM_PINS < 1 || NUM_PINS > MAX_PINS)
            $error("NUM_PINS out of range");
        if (ADDR_W < 4)
            $error("ADDR_W too small");
    end

    gpio_sync #(.W(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst_n (rst_n),
        .d   (pin_in),
        .q   (lvl_q)
    );

    gpio_edge_cap #(.W(NUM_PINS), .TRIG(TRIG)) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .lvl      (lvl_q),
        .clr_en   (cap_clr_en),
        .clr_mask (cap_clr_mask),
        .cap      (cap_q)
    );

    gpio_regs #(.W(NUM_PINS), .ADDR_W(ADDR_W)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_req      (bus_req),
        .bus_we       (bus_we),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .bus_ready    (bus_ready),
        .lvl          (lvl_q),
        .cap          (cap_q),
        .data_q       (data_q),
        .dir_q        (dir_q),
        .mask_q       (mask_q),
        .cap_clr_en   (cap_clr_en),
        .cap_clr_mask (cap_clr_mask)
    );

    if (TRIG == TRIG_LEVEL) begin : g_lvl_src
        assign irq_src = lvl_q & mask_q;
    end else begin : g_edge_src
        assign irq_src = cap_q & mask_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |irq_src;
    end

    assign irq     = irq_q;
    assign pin_out = data_q;
    assign pin_oe  = dir_q;
endmodule

// File: rtl/gpio_irq_bank_chk.sv
module gpio_irq_bank_chk
    import gpio_pkg::*;
#(
    parameter int    W    = 8,
    parameter trig_e TRIG = TRIG_RISE
) (
    input logic         clk,
    input logic         rst_n,
    input logic         bus_req,
    input logic         bus_ready,
    input logic         irq,
    input logic [W-1:0] lvl_q,
    input logic [W-1:0] mask_q,
    input logic [W-1:0] cap_q,
    input logic         cap_clr_en
);
    p_ready_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ready |=> !bus_ready);

    p_ready_after_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ready) |=> bus_ready);

    p_mask_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |=> !irq);

    p_cap_no_lost_bit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_clr_en |=> ((cap_q & $past(cap_q)) == $past(cap_q)));

    if (TRIG == TRIG_LEVEL) begin : g_lvl
        p_irq_from_level_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (|(lvl_q & mask_q)) |=> irq);
        p_cap_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
            cap_q == '0);
    end else begin : g_edge
        p_irq_from_cap_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (|(cap_q & mask_q)) |=> irq);
    end
endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(.W(NUM_PINS), .TRIG(TRIG)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_req    (bus_req),
    .bus_ready  (bus_ready),
    .irq        (irq),
    .lvl_q      (lvl_q),
    .mask_q     (mask_q),
    .cap_q      (cap_q),
    .cap_clr_en (cap_clr_en)
);

// File: tb/gpio_irq_bank_tb.sv
module gpio_irq_bank_tb;
    import gpio_pkg::*;

    localparam int N = 4;
    localparam logic [3:0] A_DATA = 4'h0, A_DIR = 4'h4, A_MASK = 4'h8, A_CAP = 4'hC;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;   // 50 MHz

    logic        req = 1'b0, we = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [N-1:0] ext = '0;

    logic [31:0]  rd   [4];
    logic         rdy  [4];
    logic [N-1:0] po   [4];
    logic [N-1:0] poe  [4];
    logic         irqv [4];
    logic [N-1:0] pin  [4];
    logic [31:0]  rdl  [4];

    for (genvar k = 0; k < 4; k++) begin : g_pad
        assign pin[k] = (poe[k] & po[k]) | (~poe[k] & ext);
    end

    // index 0 rise, 1 fall, 2 both, 3 level
    gpio_irq_bank #(.NUM_PINS(N), .TRIG(TRIG_RISE)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_req(req), .bus_we(we), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(rd[0]), .bus_ready(rdy[0]),
        .pin_in(pin[0]), .pin_out(po[0]), .pin_oe(poe[0]), .irq(irqv[0]));
    gpio_irq_bank #(.NUM_PINS(N), .TRIG(TRIG_FALL)) u_dut_fall (
        .clk(clk), .rst_n(rst_n), .bus_req(req), .bus_we(we), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(rd[1]), .bus_ready(rdy[1]),
        .pin_in(pin[1]), .pin_out(po[1]), .pin_oe(poe[1]), .irq(irqv[1]));
    gpio_irq_bank #(.NUM_PINS(N), .TRIG(TRIG_BOTH)) u_dut_both (
        .clk(clk), .rst_n(rst_n), .bus_req(req), .bus_we(we), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(rd[2]), .bus_ready(rdy[2]),
        .pin_in(pin[2]), .pin_out(po[2]), .pin_oe(poe[2]), .irq(irqv[2]));
    gpio_irq_bank #(.NUM_PINS(N), .TRIG(TRIG_LEVEL)) u_dut_lvl (
        .clk(clk), .rst_n(rst_n), .bus_req(req), .bus_we(we), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(rd[3]), .bus_ready(rdy[3]),
        .pin_in(pin[3]), .pin_out(po[3]), .pin_oe(poe[3]), .irq(irqv[3]));

    int nchk = 0;
    int nfail = 0;
    bit done = 1'b0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one bus access; ready checked (R2), read words kept in rdl
    task automatic xfer(input logic w, input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        req = 1'b1; we = w; addr = a; wdata = d;
        @(negedge clk);
        req = 1'b0; we = 1'b0;
        for (int k = 0; k < 4; k++) begin
            chk($sformatf("R2 ready inst%0d", k), {31'd0, rdy[k]}, 32'd1);
            rdl[k] = rd[k];
        end
        @(negedge clk);
        chk("R2 ready one cycle", {31'd0, rdy[0]}, 32'd0);
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic read_all(input logic [3:0] a, input string tag, input logic [31:0] e0,
                            input logic [31:0] e1, input logic [31:0] e2, input logic [31:0] e3);
        xfer(1'b0, a, '0);
        chk({tag, " rise"}, rdl[0], e0);
        chk({tag, " fall"}, rdl[1], e1);
        chk({tag, " both"}, rdl[2], e2);
        chk({tag, " level"}, rdl[3], e3);
    endtask

    initial begin
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(1);
        // R1 reset state
        for (int k = 0; k < 4; k++) begin
            chk("R1 oe", {28'd0, poe[k]}, 32'd0);
            chk("R1 irq", {31'd0, irqv[k]}, 32'd0);
            chk("R1 ready", {31'd0, rdy[k]}, 32'd0);
        end
        read_all(A_DIR,  "R1 dir",  0, 0, 0, 0);
        read_all(A_MASK, "R1 mask", 0, 0, 0, 0);
        read_all(A_CAP,  "R1 cap",  0, 0, 0, 0);

        // R2/R4 register map and upper bits
        for (int v = 0; v < 16; v++) begin
            xfer(1'b1, A_MASK, 32'hFFFF_FFF0 | v);
            xfer(1'b1, A_DIR, 32'h5A5A_5A50 | (15 - v));
            read_all(A_MASK, "R4 mask upper", v, v, v, v);
            read_all(A_DIR, "R2 dir", 15 - v, 15 - v, 15 - v, 15 - v);
        end
        xfer(1'b1, A_MASK, 0);

        // R3/R4 drive and readback over all dir x data
        for (int v = 0; v < 16; v++) begin
            for (int w = 0; w < 16; w++) begin
                logic [3:0] e;
                ext = ~w[3:0];
                xfer(1'b1, A_DIR, v);
                xfer(1'b1, A_DATA, 32'hFFFF_FFF0 | w);
                chk("R3 oe", {28'd0, poe[0]}, v);
                chk("R3 out", {28'd0, po[0]}, w);
                wait_cyc(3);
                e = (v[3:0] & w[3:0]) | (~v[3:0] & ext);
                read_all(A_DATA, "R4 data level", e, e, e, e);
            end
        end
        xfer(1'b1, A_DIR, 0);
        ext = '0;
        wait_cyc(4);
        xfer(1'b1, A_CAP, 32'hF);

        // R5 single-pin edges, R9 capture empty in level mode
        for (int p = 0; p < N; p++) begin
            logic [31:0] b;
            b = 32'd1 << p;
            ext[p] = 1'b1;
            wait_cyc(4);
            read_all(A_CAP, "R5 rise edge", b, 0, b, 0);
            xfer(1'b1, A_CAP, 32'hF);
            ext[p] = 1'b0;
            wait_cyc(4);
            read_all(A_CAP, "R5 fall edge", 0, b, b, 0);
            xfer(1'b1, A_CAP, 32'hF);
        end

        // R6 write-one-to-clear over every pattern
        for (int c = 0; c < 16; c++) begin
            ext = '0;
            wait_cyc(4);
            xfer(1'b1, A_CAP, 32'hF);
            ext = 4'hF;
            wait_cyc(4);
            xfer(1'b1, A_CAP, c);
            read_all(A_CAP, "R6 w1c", 4'hF & ~c[3:0], 0, 4'hF & ~c[3:0], 0);
        end

        // R8/R10 interrupt vs enable with all rise/both bits captured
        xfer(1'b1, A_CAP, 32'hF);
        ext = '0;
        wait_cyc(4);
        xfer(1'b1, A_CAP, 32'hF);
        ext = 4'hF;
        wait_cyc(4);
        for (int m = 0; m < 16; m++) begin
            logic [31:0] e;
            xfer(1'b1, A_MASK, m);
            wait_cyc(2);
            e = (m != 0) ? 32'd1 : 32'd0;
            chk("R8 irq rise", {31'd0, irqv[0]}, e);
            chk("R10 irq fall nothing captured", {31'd0, irqv[1]}, 0);
            chk("R8 irq both", {31'd0, irqv[2]}, e);
            chk("R9 irq level all high", {31'd0, irqv[3]}, e);
        end
        xfer(1'b1, A_CAP, 32'hF);
        wait_cyc(2);
        chk("R8 irq drops after clear rise", {31'd0, irqv[0]}, 0);
        chk("R8 irq drops after clear both", {31'd0, irqv[2]}, 0);

        // R9/R10 level mode over every level x enable pair
        for (int e = 0; e < 16; e++) begin
            ext = e[3:0];
            for (int m = 0; m < 16; m++) begin
                logic [3:0] lm;
                xfer(1'b1, A_MASK, m);
                wait_cyc(4);
                lm = e[3:0] & m[3:0];
                chk("R9 R10 level irq", {31'd0, irqv[3]}, (lm != 0) ? 32'd1 : 32'd0);
            end
        end

        // R7 edge coinciding with clearing write on pin 0
        xfer(1'b1, A_MASK, 0);
        ext = '0;
        wait_cyc(4);
        xfer(1'b1, A_CAP, 32'hF);
        ext = 4'h1;
        wait_cyc(4);
        read_all(A_CAP, "R7 armed", 1, 0, 1, 0);
        @(negedge clk);
        ext = 4'h0;
        @(posedge clk);
        @(posedge clk);
        xfer(1'b1, A_CAP, 32'h1);   // sampled on the edge that records the fall
        read_all(A_CAP, "R7 set beats clear", 0, 1, 1, 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end
endmodule